// File: doc/BRIEF.md
# Extended Capability List Walker

This block follows the chain of extended capability headers kept in a 4 KiB configuration space. The space is reached through a single-port, 32-bit, dword-addressed memory port. Read data returns one cycle after the request. Each header word holds three fields. The 16-bit capability ID sits in bits 15:0, a 4-bit version in bits 19:16, and a 12-bit byte offset of the following header in bits 31:20. The chain always starts at byte offset 0x100.

A find command takes a capability ID. It returns the offset of the first header carrying that ID, and the offset of the header visited just before it. An append command adds a new header at a caller-chosen offset. When that offset is not 0x100, the engine runs the same walk with ID matching switched off, which brings it to the tail of the chain. It rewrites only the tail's next field and then writes the new header with a zero next field. An append at 0x100 starts a fresh chain with a single write.

Commands are taken on a valid pulse while the block is idle. A one-cycle done strobe marks the point where the result, previous offset and error flag are valid. They stay valid until the next command is accepted.

Top module: `ecap_walker`

## Requirements
- R1: After reset, busy, done, err and mem_req are all 0.
- R2: A find (cmd_op = 0) starts at 0x100 and compares bits 15:0 of each header with cmd_id. On the first match, res_off is that header's offset and res_prev is the offset visited before it (0 when the match is at 0x100).
- R3: If the header word at 0x100 is all zero, the list is empty: a find ends with res_off = 0, res_prev = 0 and err = 0.
- R4: A find that reaches a header whose next field (bits 31:20) is 0 without a match ends with res_off = 0, err = 0, and res_prev equal to that last header's offset.
- R5: A next field that is nonzero but below 0x100, above 0xFF8, or has bits 1:0 set ends the command with err = 1. Every error leaves res_off = 0 and res_prev = 0.
- R6: A walk that has read MAX_STEPS headers (default 1024) and would read another ends with err = 1. This stops a circular chain.
- R7: An append (cmd_op = 1) at offset 0x100 reads nothing. It writes {12'h000, cmd_ver, cmd_id} at 0x100 and returns res_off = 0x100, res_prev = 0.
- R8: An append at any other valid offset ignores ID matches and walks to the tail. It writes the tail's word back with only bits 31:20 replaced by cmd_off, then writes {12'h000, cmd_ver, cmd_id} at cmd_off. It returns res_off = cmd_off and res_prev = the tail offset.
- R9: An append raises err and writes nothing in any of these cases: cmd_off below 0x100, cmd_off not dword aligned, cmd_size below 8, cmd_off + cmd_size above 4096, or an empty list with cmd_off not 0x100.
- R10: busy is high from the cycle after acceptance until done. done is a single-cycle pulse, after which busy drops. cmd_valid while busy is ignored. No memory access happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 1 | 0 = find, 1 = append |
| cmd_id | input | 16 | Capability ID to find or to place |
| cmd_ver | input | 4 | Version of the appended header |
| cmd_off | input | 12 | Byte offset of the appended header |
| cmd_size | input | 13 | Byte size of the appended region |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last command failed |
| res_off | output | 12 | Matched or placed offset, 0 on miss or error |
| res_prev | output | 12 | Previous or tail offset |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 10 | Dword address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |

## Verification
The assertions assume that the memory answers every read exactly one cycle after the request. They also assume that nothing outside the block changes the configuration space while a command runs, since the checker's read count and write-ownership rules rely on the engine being the only user of the port. The stimulus holds to this: it reloads the memory model only while busy is low. Random appends choose offsets that hold no existing header, so a patch never lands on the chain it is walking. Circular chains and illegal next fields appear only in directed cases with known outcomes.

// File: rtl/ecap_pkg.sv
// Shared types and constants for the extended capability list walker.
// Assumes a 4 KiB configuration space, so offsets are 12 bits wide.
package ecap_pkg;
    localparam int          OFF_W     = 12;
    localparam int          WORD_AW   = OFF_W - 2;
    localparam int          SIZE_W    = OFF_W + 1;
    localparam logic [11:0] LIST_BASE = 12'h100;
    localparam logic [11:0] LAST_HDR  = 12'hFF8;
    localparam int          SPACE_B   = 1 << OFF_W;

    typedef struct packed {
        logic [11:0] nxt;
        logic [3:0]  ver;
        logic [15:0] id;
    } ecap_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_EVAL, ST_PATCH, ST_PLACE, ST_DONE
    } walk_st_t;
endpackage

// File: rtl/ecap_offset_chk.sv
// Combinational legality test for a header offset: inside [LO, HI] and
// dword aligned. Assumes LO and HI are themselves aligned.
module ecap_offset_chk #(
    parameter int          OFF_W = 12,
    parameter logic [11:0] LO    = 12'h100,
    parameter logic [11:0] HI    = 12'hFF8
) (
    input  logic [OFF_W-1:0] off,
    output logic             ok
);
    // range and alignment test
    always_comb begin
        ok = (off >= LO) && (off <= HI) && (off[1:0] == 2'b00);
    end
endmodule

// File: rtl/ecap_step_ctr.sv
// Counts headers read during one walk and flags the read that reaches the
// limit. Assumes clr is raised at command acceptance.
module ecap_step_ctr #(
    parameter int MAX_STEPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_STEPS + 1);

    logic [CW-1:0] cnt;

    // count completed reads that led to a further hop
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(MAX_STEPS - 1));
endmodule

// File: rtl/ecap_walker.sv
// Walks the extended capability header chain for find and append commands.
// Assumes a synchronous memory that returns read data one cycle after the
// request and that nothing else writes the space while busy is high.
module ecap_walker
    import ecap_pkg::*;
#(
    parameter int MAX_STEPS = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_op,
    input  logic [15:0]         cmd_id,
    input  logic [3:0]          cmd_ver,
    input  logic [OFF_W-1:0]    cmd_off,
    input  logic [SIZE_W-1:0]   cmd_size,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [OFF_W-1:0]    res_off,
    output logic [OFF_W-1:0]    res_prev,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_AW-1:0]  mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic [31:0]         mem_rdata
);
    walk_st_t         st;
    logic             app_q;
    logic [15:0]      id_q;
    logic [3:0]       ver_q;
    logic [OFF_W-1:0] off_q, cur_q, prev_q, tail_q;
    logic [19:0]      tail_lo_q;
    logic [OFF_W-1:0] res_off_q, res_prev_q;
    logic             err_q;

    ecap_hdr_t        hdr;
    logic             nxt_ok, new_ok, size_ok, step_last, step_inc, accept;

    assign hdr    = ecap_hdr_t'(mem_rdata);
    assign accept = (st == ST_IDLE) && cmd_valid;

    ecap_offset_chk #(.OFF_W(OFF_W), .LO(LIST_BASE), .HI(LAST_HDR)) u_nxt_chk (
        .off (hdr.nxt),
        .ok  (nxt_ok)
    );

    ecap_offset_chk #(.OFF_W(OFF_W), .LO(LIST_BASE), .HI(LAST_HDR)) u_new_chk (
        .off (cmd_off),
        .ok  (new_ok)
    );

    ecap_step_ctr #(.MAX_STEPS(MAX_STEPS)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (step_inc),
        .last  (step_last)
    );

    // append region: at least 8 bytes and ending inside the space
    always_comb begin
        size_ok = (cmd_size >= SIZE_W'(8)) &&
                  ((32'(cmd_off) + 32'(cmd_size)) <= 32'(SPACE_B));
    end

    // a further hop is taken when the current header neither ends nor matches
    always_comb begin
        step_inc = (st == ST_EVAL) && !(prev_q == '0 && hdr == '0) &&
                   !(!app_q && hdr.id == id_q) && (hdr.nxt != '0) &&
                   nxt_ok && !step_last;
    end

    // command sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            app_q      <= 1'b0;
            id_q       <= '0;
            ver_q      <= '0;
            off_q      <= '0;
            cur_q      <= '0;
            prev_q     <= '0;
            tail_q     <= '0;
            tail_lo_q  <= '0;
            res_off_q  <= '0;
            res_prev_q <= '0;
            err_q      <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        app_q      <= cmd_op;
                        id_q       <= cmd_id;
                        ver_q      <= cmd_ver;
                        off_q      <= cmd_off;
                        cur_q      <= LIST_BASE;
                        prev_q     <= '0;
                        tail_q     <= '0;
                        err_q      <= 1'b0;
                        res_off_q  <= '0;
                        res_prev_q <= '0;
                        if (cmd_op && !(new_ok && size_ok)) begin
                            err_q <= 1'b1;
                            st    <= ST_DONE;
                        end else if (cmd_op && cmd_off == LIST_BASE) begin
                            st <= ST_PLACE;
                        end else begin
                            st <= ST_READ;
                        end
                    end
                end
                ST_READ: st <= ST_EVAL;
                ST_EVAL: begin
                    if (prev_q == '0 && hdr == '0) begin
                        err_q <= app_q;
                        st    <= ST_DONE;
                    end else if (!app_q && hdr.id == id_q) begin
                        res_off_q  <= cur_q;
                        res_prev_q <= prev_q;
                        st         <= ST_DONE;
                    end else if (hdr.nxt == '0) begin
                        if (app_q) begin
                            tail_q    <= cur_q;
                            tail_lo_q <= mem_rdata[19:0];
                            st        <= ST_PATCH;
                        end else begin
                            res_prev_q <= cur_q;
                            st         <= ST_DONE;
                        end
                    end else if (!nxt_ok || step_last) begin
                        err_q <= 1'b1;
                        st    <= ST_DONE;
                    end else begin
                        prev_q <= cur_q;
                        cur_q  <= hdr.nxt;
                        st     <= ST_READ;
                    end
                end
                ST_PATCH: st <= ST_PLACE;
                ST_PLACE: begin
                    res_off_q  <= off_q;
                    res_prev_q <= tail_q;
                    st         <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // memory port drive per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q[OFF_W-1:2];
        mem_wdata = '0;
        case (st)
            ST_READ:  mem_req = 1'b1;
            ST_PATCH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tail_q[OFF_W-1:2];
                mem_wdata = {off_q, tail_lo_q};
            end
            ST_PLACE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = off_q[OFF_W-1:2];
                mem_wdata = {12'h000, ver_q, id_q};
            end
            default: ;
        endcase
    end

    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_DONE);
    assign err      = err_q;
    assign res_off  = res_off_q;
    assign res_prev = res_prev_q;
endmodule

// File: rtl/ecap_walker_chk.sv
// Protocol checker for ecap_walker, attached by bind. Tracks the accepted
// operation and the number of reads per command on its own.
module ecap_walker_chk
    import ecap_pkg::*;
#(
    parameter int MAX_STEPS = 1024
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_op,
    input logic [15:0]         cmd_id,
    input logic [3:0]          cmd_ver,
    input logic [OFF_W-1:0]    cmd_off,
    input logic [SIZE_W-1:0]   cmd_size,
    input logic                busy,
    input logic                done,
    input logic                err,
    input logic [OFF_W-1:0]    res_off,
    input logic [OFF_W-1:0]    res_prev,
    input logic                mem_req,
    input logic                mem_we,
    input logic [WORD_AW-1:0]  mem_addr,
    input logic [31:0]         mem_wdata,
    input logic [31:0]         mem_rdata
);
    localparam int RW = $clog2(MAX_STEPS + 2);

    logic          app_seen;
    logic [RW-1:0] rd_cnt;

    // remember the operation of the accepted command
    always_ff @(posedge clk) begin
        if (!rst_n)                  app_seen <= 1'b0;
        else if (cmd_valid && !busy) app_seen <= cmd_op;
    end

    // count reads issued during one command
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)       rd_cnt <= '0;
        else if (mem_req && !mem_we) rd_cnt <= rd_cnt + 1'b1;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    // R10
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
    // R8
    write_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && app_seen));
    // R5
    err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (res_off == '0 && res_prev == '0));
    // R2
    hit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !app_seen && res_off != '0) |->
        (res_off >= LIST_BASE && res_off <= LAST_HDR && res_off[1:0] == 2'b00));
    // R6
    read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= RW'(MAX_STEPS));
endmodule

bind ecap_walker ecap_walker_chk #(.MAX_STEPS(MAX_STEPS)) u_chk (.*);

// File: tb/ecap_walker_tb.sv
`timescale 1ns/1ps
module ecap_walker_tb;
    localparam int MAX_STEPS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [15:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0;
    logic [12:0] cmd_size = '0;
    logic        busy, done, err;
    logic [11:0] res_off, res_prev;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem     [0:1023];
    logic [31:0] exp_mem [0:1023];
    logic        tb_load = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [11:0] lst_off [0:7];
    logic [15:0] lst_id  [0:7];
    int          lst_n;

    always #2 clk = ~clk;

    ecap_walker #(.MAX_STEPS(MAX_STEPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
        .busy(busy), .done(done), .err(err), .res_off(res_off), .res_prev(res_prev),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: bulk load from the shadow while idle, else serve the port
    always @(posedge clk) begin
        if (tb_load) begin
            for (int i = 0; i < 1024; i++) mem[i] <= exp_mem[i];
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic clear_shadow();
        for (int i = 0; i < 1024; i++) exp_mem[i] = '0;
    endtask

    task automatic load_mem();
        @(negedge clk) tb_load = 1'b1;
        @(negedge clk) tb_load = 1'b0;
    endtask

    task automatic build_list();
        clear_shadow();
        for (int i = 0; i < lst_n; i++) begin
            logic [11:0] nx;
            nx = (i < lst_n - 1) ? lst_off[i+1] : 12'h000;
            exp_mem[lst_off[i][11:2]] = {nx, 4'(i), lst_id[i]};
        end
        load_mem();
    endtask

    task automatic model_walk(input logic [15:0] id, input bit match_en,
                              output logic [11:0] o_off, output logic [11:0] o_prev,
                              output bit o_err);
        logic [11:0] cur, prv;
        logic [31:0] h;
        o_off = '0; o_prev = '0; o_err = 1'b0;
        cur = 12'h100; prv = '0;
        if (exp_mem[64] == '0) return;
        for (int steps = 1; steps <= MAX_STEPS; steps++) begin
            h = exp_mem[cur[11:2]];
            if (match_en && h[15:0] == id) begin
                o_off = cur; o_prev = prv; return;
            end
            if (h[31:20] == 12'h000) begin
                o_prev = cur; return;
            end
            if (h[31:20] < 12'h100 || h[31:20] > 12'hFF8 || h[21:20] != 2'b00 ||
                steps == MAX_STEPS) begin
                o_err = 1'b1; return;
            end
            prv = cur; cur = h[31:20];
        end
    endtask

    task automatic model_cmd(input bit op, input logic [15:0] id, input logic [3:0] ver,
                             input logic [11:0] off, input logic [12:0] size,
                             output logic [11:0] eo, output logic [11:0] ep,
                             output bit ee);
        logic [11:0] wo, wp;
        bit we_;
        eo = '0; ep = '0; ee = 1'b0;
        if (!op) begin
            model_walk(id, 1'b1, eo, ep, ee);
        end else if (off < 12'h100 || off[1:0] != 2'b00 || size < 13'd8 ||
                     (int'(off) + int'(size)) > 4096) begin
            ee = 1'b1;
        end else if (off == 12'h100) begin
            exp_mem[64] = {12'h000, ver, id};
            eo = off;
        end else if (exp_mem[64] == '0) begin
            ee = 1'b1;
        end else begin
            model_walk(id, 1'b0, wo, wp, we_);
            if (we_) ee = 1'b1;
            else begin
                exp_mem[wp[11:2]][31:20] = off;
                exp_mem[off[11:2]] = {12'h000, ver, id};
                eo = off; ep = wp;
            end
        end
    endtask

    task automatic issue(input bit op, input logic [15:0] id, input logic [3:0] ver,
                         input logic [11:0] off, input logic [12:0] size);
        @(negedge clk);
        cmd_op = op; cmd_id = id; cmd_ver = ver; cmd_off = off; cmd_size = size;
        cmd_valid = 1'b1;
        @(negedge clk) cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic compare_mem(input string tag);
        int bad_i;
        bad_i = -1;
        for (int i = 0; i < 1024; i++)
            if (bad_i < 0 && mem[i] !== exp_mem[i]) bad_i = i;
        if (bad_i < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, {tag, " memory"}, mem[bad_i], exp_mem[bad_i]);
    endtask

    task automatic run_cmd(input bit op, input logic [15:0] id, input logic [3:0] ver,
                           input logic [11:0] off, input logic [12:0] size,
                           input string tag);
        logic [11:0] eo, ep;
        bit ee;
        model_cmd(op, id, ver, off, size, eo, ep, ee);
        issue(op, id, ver, off, size);
        wait_done();
        check(err == ee,      {tag, " err"},      32'(err),      32'(ee));
        check(res_off == eo,  {tag, " res_off"},  32'(res_off),  32'(eo));
        check(res_prev == ep, {tag, " res_prev"}, 32'(res_prev), 32'(ep));
        @(negedge clk);
        compare_mem(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        clear_shadow();
        repeat (4) @(negedge clk);
        load_mem();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err && !mem_req, "R1 reset outputs",
              {busy, done, err, mem_req}, 0);

        // R3 empty list
        run_cmd(1'b0, 16'h0001, 4'h0, 12'h000, 13'd0, "R3 empty find");
        // R3 empty list with ID zero still reports empty
        run_cmd(1'b0, 16'h0000, 4'h0, 12'h000, 13'd0, "R3 empty find id0");

        // R2 single header at the base
        lst_n = 1; lst_off[0] = 12'h100; lst_id[0] = 16'h0001;
        build_list();
        run_cmd(1'b0, 16'h0001, 4'h0, 12'h000, 13'd0, "R2 match at base");

        // R2 R4 three-entry chain
        lst_n = 3;
        lst_off[0] = 12'h100; lst_id[0] = 16'h000B;
        lst_off[1] = 12'h140; lst_id[1] = 16'h0003;
        lst_off[2] = 12'h200; lst_id[2] = 16'h0010;
        build_list();
        run_cmd(1'b0, 16'h0010, 4'h0, 12'h000, 13'd0, "R2 match at tail");
        run_cmd(1'b0, 16'h0003, 4'h0, 12'h000, 13'd0, "R2 match middle");
        run_cmd(1'b0, 16'h0077, 4'h0, 12'h000, 13'd0, "R4 miss");

        // R5 illegal next pointers
        clear_shadow(); exp_mem[64] = {12'h142, 4'h1, 16'h0002}; load_mem();
        run_cmd(1'b0, 16'h0009, 4'h0, 12'h000, 13'd0, "R5 misaligned next");
        clear_shadow(); exp_mem[64] = {12'h080, 4'h1, 16'h0002}; load_mem();
        run_cmd(1'b0, 16'h0009, 4'h0, 12'h000, 13'd0, "R5 next below base");
        clear_shadow(); exp_mem[64] = {12'hFFC, 4'h1, 16'h0002}; load_mem();
        run_cmd(1'b0, 16'h0009, 4'h0, 12'h000, 13'd0, "R5 next above top");
        clear_shadow(); exp_mem[64] = {12'hFF8, 4'h1, 16'h0002};
        exp_mem[1022] = {12'h000, 4'h1, 16'h0005}; load_mem();
        run_cmd(1'b0, 16'h0005, 4'h0, 12'h000, 13'd0, "R5 next at top limit");

        // R6 circular chain
        clear_shadow(); exp_mem[64] = {12'h100, 4'h1, 16'h0001}; load_mem();
        run_cmd(1'b0, 16'h0002, 4'h0, 12'h000, 13'd0, "R6 loop");

        // R7 append at base on empty space
        clear_shadow(); load_mem();
        run_cmd(1'b1, 16'h0018, 4'h2, 12'h100, 13'd8, "R7 append base");

        // R8 append ignores ID matches and links at the tail
        lst_n = 3;
        lst_off[0] = 12'h100; lst_id[0] = 16'h000B;
        lst_off[1] = 12'h140; lst_id[1] = 16'h0003;
        lst_off[2] = 12'h200; lst_id[2] = 16'h0010;
        build_list();
        run_cmd(1'b1, 16'h000B, 4'h1, 12'h300, 13'd16, "R8 append tail");
        run_cmd(1'b0, 16'h000B, 4'h0, 12'h000, 13'd0, "R8 first id still wins");

        // R9 bad append arguments
        run_cmd(1'b1, 16'h0001, 4'h1, 12'h0FC, 13'd8,  "R9 below base");
        run_cmd(1'b1, 16'h0001, 4'h1, 12'h402, 13'd8,  "R9 misaligned");
        run_cmd(1'b1, 16'h0001, 4'h1, 12'h400, 13'd4,  "R9 size small");
        run_cmd(1'b1, 16'h0001, 4'h1, 12'hFF8, 13'd16, "R9 past end");
        run_cmd(1'b1, 16'h0001, 4'h1, 12'hFF8, 13'd8,  "R9 exact end ok");
        clear_shadow(); load_mem();
        run_cmd(1'b1, 16'h0001, 4'h1, 12'h300, 13'd8,  "R9 empty append");

        // R10 commands ignored while busy, done is one cycle
        begin
            logic [11:0] eo, ep;
            bit ee;
            clear_shadow(); exp_mem[64] = {12'h100, 4'h1, 16'h0001}; load_mem();
            model_cmd(1'b0, 16'h0002, 4'h0, 12'h000, 13'd0, eo, ep, ee);
            issue(1'b0, 16'h0002, 4'h0, 12'h000, 13'd0);
            check(busy, "R10 busy after accept", 32'(busy), 1);
            issue(1'b1, 16'h0033, 4'h1, 12'h100, 13'd8);
            wait_done();
            check(err == ee, "R10 first command result", 32'(err), 32'(ee));
            @(negedge clk);
            check(!done && !busy, "R10 done single pulse", {done, busy}, 0);
            compare_mem("R10 ignored append wrote nothing");
        end

        // random lists, finds and appends against the model
        for (int it = 0; it < 40; it++) begin
            lst_n = 1 + int'($urandom % 7);
            lst_off[0] = 12'h100;
            for (int i = 1; i < lst_n; i++) begin
                bit dup;
                do begin
                    lst_off[i] = 12'h104 + 12'(4 * ($urandom % 950));
                    dup = 1'b0;
                    for (int j = 0; j < i; j++) if (lst_off[j] == lst_off[i]) dup = 1'b1;
                end while (dup);
            end
            for (int i = 0; i < lst_n; i++) lst_id[i] = 16'($urandom % 24);
            build_list();
            if ($urandom % 2 == 0) begin
                logic [15:0] fid;
                fid = ($urandom % 2 == 0) ? lst_id[$urandom % lst_n] : 16'($urandom);
                run_cmd(1'b0, fid, 4'h0, 12'h000, 13'd0, "R2 R4 random find");
            end else begin
                logic [11:0] aoff;
                bit dup;
                do begin
                    aoff = 12'h104 + 12'(4 * ($urandom % 950));
                    dup = 1'b0;
                    for (int j = 0; j < lst_n; j++) if (lst_off[j] == aoff) dup = 1'b1;
                end while (dup);
                if ($urandom % 5 == 0) aoff = aoff | 12'h001;
                run_cmd(1'b1, 16'($urandom), 4'($urandom), aoff,
                        13'(8 + 4 * ($urandom % 4)), "R8 R9 random append");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule